// File: doc/BRIEF.md
# Circular-buffer DMA repeat sequencer

This block is a single DMA channel that only runs in repeat mode. For each transfer it reads one byte or word from a source address and writes it to a destination address. One end of the transfer is a memory-side pointer that steps after every transfer. The other end is a fixed peripheral-side address. A transfer counter is reloaded automatically, and at the same moment the memory pointer is wound back to where the run began. Software can therefore set up a circular buffer once and leave the channel to cycle through it indefinitely.

Software loads the pointers, the counts and the mode through a small register write port, then sets the enable bit. Each accepted transfer request starts one read-then-write pair of cycles on a simple bus master port, and the bus acknowledge ends each cycle. Clearing enable freezes the channel. Setting enable again continues from the frozen position. No interrupt is ever produced.

Top module: `dmarep_top`

## Requirements
- R1: After reset every register is zero, the channel is disabled and neither `bus_rd` nor `bus_wr` is asserted.
- R2: Register select codes are 0 memory pointer (24 bits), 1 peripheral address (8 bits), 2 active count, 3 initial count and 4 control. Control bits are: bit 0 enable, bit 1 decrement, bit 2 word size, bit 3 serial-receive activation. Writes to selects 0 to 3 are ignored while enabled. A control write made while enabled changes only the enable bit.
- R3: The peripheral-side effective address is the 8-bit register with its upper 16 bits forced to ones. It never changes while the channel is enabled.
- R4: With control bit 3 set, only `req_rx` requests transfers, the read goes to the peripheral address and the write goes to the memory pointer. With bit 3 clear, only `req_gen` requests transfers and the two roles are swapped. A request on the unselected input causes no bus activity.
- R5: A request sampled high at a clock edge makes the channel pending. At the next edge, if the channel is idle, `bus_rd` asserts. After the read acknowledge, `bus_wr` asserts with the captured read data on `bus_wdata`. The write acknowledge returns the channel to idle. `bus_word` reflects the size bit.
- R6: On each write acknowledge the memory pointer moves up (decrement bit 0) or down (decrement bit 1) by 1 for byte size or 2 for word size.
- R7: On each write acknowledge the active count decrements by one. When the count reaches zero it is reloaded from the initial count, and the memory pointer is rewound by step times the initial count, so the next transfer uses the starting address again. The initial count is never changed by hardware.
- R8: An initial count of zero means 256 transfers per cycle of the buffer.
- R9: While disabled, no new transfer starts and the pointers and count are kept. Re-enabling resumes from exactly that state.
- R10: At most one request is held pending. A request that arrives while a transfer runs adds at most one more transfer, and requests seen while disabled are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 24 | Register write data |
| req_rx | input | 1 | Serial-receive-full transfer request |
| req_gen | input | 1 | Generic transfer request |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_word | output | 1 | 1 for word, 0 for byte |
| bus_addr | output | 24 | Cycle address |
| bus_wdata | output | 16 | Write data (captured read data) |
| bus_rdata | input | 16 | Read data |
| bus_ack | input | 1 | Cycle acknowledge |

## Verification
A request sampled at edge k raises `bus_rd` after edge k+1. `bus_wr` follows on the edge that samples the read acknowledge. The new pointer and count take effect on the edge that samples the write acknowledge, so they first show up as the address of the next read. The bench drives every input on the falling edge and keeps a behavioural model that it advances on each rising edge. On every falling edge it compares the strobes, address, size and write data with that model, so each result is checked in the exact cycle it is due. Directed checks on the logged read and write addresses cover the rewind point, the 256-transfer case, ignored writes and dropped requests.

// File: rtl/dmarep_pkg.sv
package dmarep_pkg;

    localparam int unsigned ADDR_W = 24;
    localparam int unsigned IOA_W  = 8;
    localparam int unsigned CNT_W  = 8;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned NSEL   = 5;

    localparam int unsigned CTRL_EN   = 0;
    localparam int unsigned CTRL_DEC  = 1;
    localparam int unsigned CTRL_WORD = 2;
    localparam int unsigned CTRL_RX   = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IOA_W-1:0]  ioa_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_MEM  = 3'd0,
        SEL_IO   = 3'd1,
        SEL_CUR  = 3'd2,
        SEL_INIT = 3'd3,
        SEL_CTRL = 3'd4
    } regsel_e;

    typedef struct packed {
        logic en;
        logic dec;
        logic word;
        logic rx_src;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xfer_st_e;

    typedef struct packed {
        addr_t src;
        addr_t dst;
    } ends_t;

    // Peripheral address widened with ones in the upper bits
    function automatic addr_t io_ea(ioa_t a);
        return {{(ADDR_W-IOA_W){1'b1}}, a};
    endfunction

    function automatic addr_t step_of(logic word);
        return word ? addr_t'(2) : addr_t'(1);
    endfunction

    // Bytes covered by one buffer cycle: count (0 means 2^CNT_W) scaled by size
    function automatic addr_t span_of(logic word, cnt_t n);
        addr_t len;
        len = (n == '0) ? addr_t'(32'd1 << CNT_W) : addr_t'(n);
        return word ? (len << 1) : len;
    endfunction

endpackage

// File: rtl/dmarep_regs.sv
module dmarep_regs
    import dmarep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  addr_t            cfg_wdata,
    input  logic             upd,
    input  addr_t            mem_nxt,
    input  cnt_t             cnt_nxt,
    output mode_t            mode_q,
    output addr_t            mem_q,
    output ioa_t             io_q,
    output cnt_t             cnt_q,
    output cnt_t             init_q
);

    logic [NSEL-1:0] hit;
    logic            wr_open;

    genvar gi;
    generate
        for (gi = 0; gi < NSEL; gi++) begin : g_dec
            assign hit[gi] = cfg_we && (cfg_sel == SEL_W'(gi));
        end
    endgenerate

    assign wr_open = ~mode_q.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            mem_q  <= '0;
            io_q   <= '0;
            cnt_q  <= '0;
            init_q <= '0;
        end else begin
            if (upd) begin
                mem_q <= mem_nxt;
                cnt_q <= cnt_nxt;
            end
            if (hit[SEL_MEM] && wr_open)
                mem_q <= cfg_wdata;
            if (hit[SEL_IO] && wr_open)
                io_q <= cfg_wdata[IOA_W-1:0];
            if (hit[SEL_CUR] && wr_open)
                cnt_q <= cfg_wdata[CNT_W-1:0];
            if (hit[SEL_INIT] && wr_open)
                init_q <= cfg_wdata[CNT_W-1:0];
            if (hit[SEL_CTRL]) begin
                mode_q.en <= cfg_wdata[CTRL_EN];
                if (wr_open) begin
                    mode_q.dec    <= cfg_wdata[CTRL_DEC];
                    mode_q.word   <= cfg_wdata[CTRL_WORD];
                    mode_q.rx_src <= cfg_wdata[CTRL_RX];
                end
            end
        end
    end

    // R3
    io_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mode_q.en) |-> $stable(io_q));

    // R7
    init_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mode_q.en) |-> $stable(init_q));

    // R7
    cnt_move_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q.en) && !$stable(cnt_q)) |->
        ((cnt_q == cnt_t'($past(cnt_q) - cnt_t'(1))) || (cnt_q == init_q)));

endmodule

// File: rtl/dmarep_step.sv
module dmarep_step
    import dmarep_pkg::*;
(
    input  mode_t mode,
    input  addr_t mem_q,
    input  cnt_t  cnt_q,
    input  cnt_t  init_q,
    output addr_t mem_nxt,
    output cnt_t  cnt_nxt
);

    cnt_t  cnt_dec;
    logic  reload;
    addr_t step;
    addr_t span;
    addr_t stepped;

    always_comb begin
        cnt_dec = cnt_q - cnt_t'(1);
        reload  = (cnt_dec == '0);
        step    = step_of(mode.word);
        span    = span_of(mode.word, init_q);
        stepped = mode.dec ? (mem_q - step) : (mem_q + step);
        if (reload) begin
            cnt_nxt = init_q;
            mem_nxt = mode.dec ? (stepped + span) : (stepped - span);
        end else begin
            cnt_nxt = cnt_dec;
            mem_nxt = stepped;
        end
    end

endmodule

// File: rtl/dmarep_seq.sv
module dmarep_seq
    import dmarep_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode,
    input  addr_t mem_q,
    input  ioa_t  io_q,
    input  logic  req_rx,
    input  logic  req_gen,
    input  logic  bus_ack,
    input  data_t bus_rdata,
    output logic  bus_rd,
    output logic  bus_wr,
    output logic  bus_word,
    output addr_t bus_addr,
    output data_t bus_wdata,
    output logic  upd
);

    xfer_st_e state_q;
    logic     pend_q;
    data_t    data_q;
    logic     req_sel;
    logic     start;
    ends_t    ends;

    assign req_sel = mode.rx_src ? req_rx : req_gen;
    assign start   = (state_q == ST_IDLE) && pend_q && mode.en;

    always_comb begin
        if (mode.rx_src) begin
            ends.src = io_ea(io_q);
            ends.dst = mem_q;
        end else begin
            ends.src = mem_q;
            ends.dst = io_ea(io_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (!mode.en) begin
            pend_q <= 1'b0;
        end else if (req_sel) begin
            pend_q <= 1'b1;
        end else if (start) begin
            pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) state_q <= ST_READ;
                ST_READ: if (bus_ack) begin
                    data_q  <= bus_rdata;
                    state_q <= ST_WRITE;
                end
                ST_WRITE: if (bus_ack) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_rd    = (state_q == ST_READ);
    assign bus_wr    = (state_q == ST_WRITE);
    assign bus_addr  = bus_wr ? ends.dst : ends.src;
    assign bus_word  = mode.word;
    assign bus_wdata = data_q;
    assign upd       = bus_wr && bus_ack;

    // R5
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr) |-> $past(bus_rd && bus_ack));

    // R9
    start_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rd) |-> $past(mode.en));

    // R5
    idle_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_wr) |-> $past(bus_ack));

endmodule

// File: rtl/dmarep_top.sv
module dmarep_top
    import dmarep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_rx,
    input  logic              req_gen,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);

    mode_t mode_q;
    addr_t mem_q;
    ioa_t  io_q;
    cnt_t  cnt_q;
    cnt_t  init_q;
    addr_t mem_nxt;
    cnt_t  cnt_nxt;
    logic  upd;

    dmarep_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .upd       (upd),
        .mem_nxt   (mem_nxt),
        .cnt_nxt   (cnt_nxt),
        .mode_q    (mode_q),
        .mem_q     (mem_q),
        .io_q      (io_q),
        .cnt_q     (cnt_q),
        .init_q    (init_q)
    );

    dmarep_step u_step (
        .mode    (mode_q),
        .mem_q   (mem_q),
        .cnt_q   (cnt_q),
        .init_q  (init_q),
        .mem_nxt (mem_nxt),
        .cnt_nxt (cnt_nxt)
    );

    dmarep_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .mem_q     (mem_q),
        .io_q      (io_q),
        .req_rx    (req_rx),
        .req_gen   (req_gen),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .upd       (upd)
    );

endmodule

// File: tb/sim_dmarep_top.sv
`timescale 1ns/1ps
module sim_dmarep_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [23:0] cfg_wdata = '0;
    logic        req_rx = 1'b0;
    logic        req_gen = 1'b0;
    logic        bus_rd, bus_wr, bus_word;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_ack = 1'b0;

    always #4 clk = ~clk;

    dmarep_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_rx(req_rx), .req_gen(req_gen),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string phase = "R1";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bus responder: read data derived from address, varying acknowledge delay
    assign bus_rdata = bus_addr[15:0] ^ 16'hA55A;
    int ack_wait = 0;
    int ack_lat = 0;
    always @(negedge clk) begin
        if ((bus_rd || bus_wr) && !bus_ack) begin
            if (ack_wait >= ack_lat) begin
                bus_ack <= 1'b1;
                ack_wait = 0;
                ack_lat = (ack_lat + 1) % 3;
            end else begin
                ack_wait++;
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    // Behavioural reference model
    int          m_state;
    bit          m_pend, m_en, m_dir, m_sz, m_rx;
    logic [23:0] m_mem;
    logic [7:0]  m_io, m_cnt, m_init;
    logic [15:0] m_data;
    bit          o_en, m_req, m_start;
    int          m_n, m_step;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_pend = 0; m_en = 0; m_dir = 0; m_sz = 0; m_rx = 0;
            m_mem = '0; m_io = '0; m_cnt = '0; m_init = '0; m_data = '0;
        end else begin
            o_en = m_en;
            m_req = m_rx ? req_rx : req_gen;
            m_start = (m_state == 0) && m_pend && m_en;
            if (m_state == 0) begin
                if (m_start) m_state = 1;
            end else if (m_state == 1) begin
                if (bus_ack) begin m_data = bus_rdata; m_state = 2; end
            end else begin
                if (bus_ack) begin
                    m_step = m_sz ? 2 : 1;
                    m_n = (m_init == 0) ? 256 : int'(m_init);
                    m_mem = m_dir ? m_mem - 24'(m_step) : m_mem + 24'(m_step);
                    m_cnt = m_cnt - 8'd1;
                    if (m_cnt == 0) begin
                        m_cnt = m_init;
                        m_mem = m_dir ? m_mem + 24'(m_step * m_n) : m_mem - 24'(m_step * m_n);
                    end
                    m_state = 0;
                end
            end
            if (!o_en) m_pend = 0;
            else if (m_req) m_pend = 1;
            else if (m_start) m_pend = 0;
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: if (!o_en) m_mem = cfg_wdata;
                    3'd1: if (!o_en) m_io = cfg_wdata[7:0];
                    3'd2: if (!o_en) m_cnt = cfg_wdata[7:0];
                    3'd3: if (!o_en) m_init = cfg_wdata[7:0];
                    3'd4: begin
                        m_en = cfg_wdata[0];
                        if (!o_en) begin
                            m_dir = cfg_wdata[1]; m_sz = cfg_wdata[2]; m_rx = cfg_wdata[3];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison against the model
    logic [23:0] e_io, e_addr;
    always @(negedge clk) begin
        if (!rst && !done) begin
            e_io = {16'hFFFF, m_io};
            if (m_state == 1) e_addr = m_rx ? e_io : m_mem;
            else e_addr = m_rx ? m_mem : e_io;
            chk({phase, " rd"}, 32'(bus_rd), 32'(m_state == 1));
            chk({phase, " wr"}, 32'(bus_wr), 32'(m_state == 2));
            if (m_state != 0) begin
                chk({phase, " addr"}, 32'(bus_addr), 32'(e_addr));
                chk({phase, " size"}, 32'(bus_word), 32'(m_sz));
            end
            if (m_state == 2) chk({phase, " wdata"}, 32'(bus_wdata), 32'(m_data));
        end
    end

    // Logs of cycle start addresses
    logic [23:0] rd_q[$];
    logic [23:0] wr_q[$];
    logic        word_q[$];
    logic        prv_rd = 0, prv_wr = 0;
    always @(negedge clk) begin
        if (bus_rd && !prv_rd) begin rd_q.push_back(bus_addr); word_q.push_back(bus_word); end
        if (bus_wr && !prv_wr) wr_q.push_back(bus_addr);
        prv_rd = bus_rd;
        prv_wr = bus_wr;
    end

    task automatic wr_reg(input logic [2:0] sel, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input bit rx);
        @(negedge clk);
        if (rx) req_rx = 1'b1; else req_gen = 1'b1;
        @(negedge clk);
        req_rx = 1'b0; req_gen = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        finish_run();
    end

    int base;
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd idle", 32'(bus_rd), 0);
        chk("R1 wr idle", 32'(bus_wr), 0);

        // R4 R6 R7 generic source, byte, incrementing, count 3
        phase = "R7";
        wr_reg(3'd0, 24'h001000);
        wr_reg(3'd1, 24'h000040);
        wr_reg(3'd2, 24'h000003);
        wr_reg(3'd3, 24'h000003);
        wr_reg(3'd4, 24'h000001);
        for (int i = 0; i < 4; i++) pulse(0);
        chk("R4 first read at memory", 32'(rd_q[0]), 32'h001000);
        chk("R3 write at peripheral", 32'(wr_q[0]), 32'hFFFF40);
        chk("R6 byte step up", 32'(rd_q[2]), 32'h001002);
        chk("R7 rewind after reload", 32'(rd_q[3]), 32'h001000);

        // R2 writes while enabled are ignored
        phase = "R2";
        wr_reg(3'd1, 24'h000077);
        wr_reg(3'd0, 24'h005000);
        wr_reg(3'd3, 24'h000009);
        wr_reg(3'd2, 24'h000020);
        for (int i = 0; i < 3; i++) pulse(0);
        chk("R2 pointer write ignored", 32'(rd_q[4]), 32'h001001);
        chk("R3 peripheral write ignored", 32'(wr_q[4]), 32'hFFFF40);
        chk("R2 initial count write ignored", 32'(rd_q[6]), 32'h001000);

        // R2 control write while enabled changes only enable
        wr_reg(3'd4, 24'h000005);
        pulse(0);
        chk("R2 size kept", 32'(word_q[7]), 0);
        chk("R2 step kept", 32'(rd_q[7]), 32'h001001);

        // R9 R10 disabled: requests dropped, state kept
        phase = "R9";
        wr_reg(3'd4, 24'h000000);
        pulse(0);
        chk("R10 request dropped while disabled", 32'(rd_q.size()), 8);
        wr_reg(3'd4, 24'h000001);
        repeat (4) @(negedge clk);
        chk("R10 no stale pending after enable", 32'(rd_q.size()), 8);
        pulse(0);
        chk("R9 resume address", 32'(rd_q[8]), 32'h001002);

        // R4 R6 serial-receive source, word, decrementing
        phase = "R6";
        wr_reg(3'd4, 24'h000000);
        wr_reg(3'd0, 24'h000100);
        wr_reg(3'd2, 24'h000002);
        wr_reg(3'd3, 24'h000002);
        wr_reg(3'd4, 24'h00000F);
        pulse(0);
        chk("R4 unselected request ignored", 32'(rd_q.size()), 9);
        for (int i = 0; i < 3; i++) pulse(1);
        chk("R4 read at peripheral", 32'(rd_q[9]), 32'hFFFF40);
        chk("R4 write at memory", 32'(wr_q[9]), 32'h000100);
        chk("R6 word step down", 32'(wr_q[10]), 32'h0000FE);
        chk("R7 rewind when decrementing", 32'(wr_q[11]), 32'h000100);
        chk("R5 word size shown", 32'(word_q[9]), 1);

        // R10 request held several cycles gives at most one extra transfer
        phase = "R10";
        wr_reg(3'd4, 24'h000000);
        wr_reg(3'd0, 24'h002000);
        wr_reg(3'd2, 24'h000010);
        wr_reg(3'd3, 24'h000010);
        wr_reg(3'd4, 24'h000001);
        @(negedge clk);
        req_gen = 1'b1;
        repeat (4) @(negedge clk);
        req_gen = 1'b0;
        repeat (30) @(negedge clk);
        chk("R10 two transfers", 32'(rd_q.size()), 14);
        chk("R10 second address", 32'(rd_q[13]), 32'h002001);

        // R8 zero count means 256 transfers
        phase = "R8";
        wr_reg(3'd4, 24'h000000);
        wr_reg(3'd0, 24'h000010);
        wr_reg(3'd2, 24'h000000);
        wr_reg(3'd3, 24'h000000);
        wr_reg(3'd4, 24'h000001);
        base = rd_q.size();
        for (int i = 0; i < 257; i++) pulse(0);
        chk("R8 last of 256", 32'(rd_q[base + 255]), 32'h00010F);
        chk("R8 wrap to start", 32'(rd_q[base + 256]), 32'h000010);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule